// File: doc/BRIEF.md
# Omega Shuffle-Exchange Interconnect

This block moves up to P packets at once from P input ports to P output ports through a self-routing omega network. P is a power of two, and the network has log2(P) stages. Each stage first rotates every line index left by one bit, which is the perfect shuffle. It then passes the lines through a column of P/2 two-by-two exchange elements. Each element is set from the destination bits of the packets it holds. The first stage reads the most significant destination bit, and each later stage reads the next lower bit. A packet that wins every element it passes through comes out on the output whose index equals its destination.

The network is blocking. When two packets in one element ask for the same element output, only one of them continues. The other packet is dropped, and a flag is raised at the input index where it entered. The caller decides whether to present that packet again. The network itself is combinational. One register bank on its outputs holds the delivered valid bits, the payloads and the blocked flags, so every result appears one clock after its inputs.

Each exchange element has two named modes. In PASS mode the even line goes to the even output and the odd line goes to the odd output. In CROSS mode the two lines are swapped. An element that holds a valid packet on its even line takes its mode from that packet. Otherwise it takes its mode from the packet on its odd line. An empty element stays in PASS.

Top module: `omega_net`

## Requirements
- R1: While rst_n is low, and in the first cycle after reset, out_valid and blocked are all zero.
- R2: Inputs sampled at one rising clock edge set the outputs after that edge. If no valid input is presented at the next edge, every output valid bit and every blocked bit is clear again.
- R3: A delivered packet appears only on the output whose index equals its destination, and its payload is unchanged. Port i uses bits [i*DW +: DW] of in_dest and bits [i*W +: W] of in_data and out_data, where DW = log2(P).
- R4: A set of packets that never meets a contention is delivered in full, with no blocked bits. Examples are the identity mapping and every cyclic shift dest = (src + c) mod P.
- R5: In stage s, counted from 0, a packet on shuffled line q asks for element output (q with bit 0 cleared) OR dest bit (DW-1-s). When both packets of one element ask for the same output, the packet on the even line goes on. The packet on the odd line is dropped, and blocked is set at that packet's input index.
- R6: With 8 ports, if input 2 sends to 7 and input 6 sends to 4, output 7 receives the packet from input 2, blocked[6] is set, and nothing else is delivered or blocked.
- R7: Every valid input is either delivered or blocked, never both. So the popcount of out_valid plus the popcount of blocked equals the popcount of the in_valid that was sampled.
- R8: A packet that is the only valid input is always delivered to its destination, whatever its source and destination.
- R9: Inputs with in_valid low have no effect on any output, whatever their destination and payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | P | One valid bit per input port |
| in_dest | input | P*DW | Destination index per input port |
| in_data | input | P*W | Payload per input port |
| out_valid | output | P | One delivered-packet bit per output port |
| out_data | output | P*W | Payload per output port |
| blocked | output | P | Set at the input index of each dropped packet |

## Verification
The bench aims at three kinds of fault:
- **Bit order.** The published conflicting pair tests whether the stages read destination bits from the top down. If the order were reversed, or the shuffle rotated the wrong way, the two packets would reach the wrong outputs or would not collide.
- **Contention.** Traffic where every input sends to one output, and a stream of mixed patterns, test who wins a contention. A design that let the odd line win, or that flagged the winner, would disagree with the bench model on which bits of blocked are set. A design that dropped a lost packet without flagging it would break the count of delivered plus blocked packets.
- **Stale state and ignored inputs.** Single packets, idle cycles and invalid inputs carrying junk fields expose a design that holds stale outputs or that lets an invalid packet take part in a contention.

// File: rtl/omega_pkg.sv
package omega_pkg;
    typedef enum logic {SW_PASS = 1'b0, SW_CROSS = 1'b1} sw_mode_e;

    // one-bit left rotation of a line index within dw bits
    function automatic int shuffle_idx(input int idx, input int dw);
        int n;
        n = 1 << dw;
        return ((idx * 2) % n) + (idx / (n / 2));
    endfunction
endpackage

// File: rtl/omega_switch.sv
module omega_switch
    import omega_pkg::*;
#(
    parameter int DW  = 3,
    parameter int W   = 8,
    parameter int BIT = 2,
    parameter int PW  = 1 + 2*DW + W
) (
    input  logic [PW-1:0] a_i,
    input  logic [PW-1:0] b_i,
    output logic [PW-1:0] o0_o,
    output logic [PW-1:0] o1_o,
    output logic          lose_o,
    output logic [DW-1:0] lose_src_o
);
    localparam int VPOS = PW - 1;
    localparam int DPOS = PW - 1 - DW + BIT;

    logic     a_v, b_v, a_bit, b_bit;
    logic     conflict;
    sw_mode_e mode;
    logic [PW-1:0] b_eff;

    assign a_v   = a_i[VPOS];
    assign b_v   = b_i[VPOS];
    assign a_bit = a_i[DPOS];
    assign b_bit = b_i[DPOS];
    assign conflict = a_v && b_v && (a_bit == b_bit);

    always_comb begin
        if (a_v)      mode = a_bit ? SW_CROSS : SW_PASS;
        else if (b_v) mode = b_bit ? SW_PASS  : SW_CROSS;
        else          mode = SW_PASS;
    end

    always_comb begin
        b_eff = b_i;
        if (conflict) b_eff[VPOS] = 1'b0;
    end

    always_comb begin
        unique case (mode)
            SW_PASS:  begin o0_o = a_i;   o1_o = b_eff; end
            SW_CROSS: begin o0_o = b_eff; o1_o = a_i;   end
            default:  begin o0_o = a_i;   o1_o = b_eff; end
        endcase
    end

    assign lose_o     = conflict;
    assign lose_src_o = b_i[W +: DW];

    // R4
    always_comb begin
        if (a_v && b_v && (a_bit != b_bit))
            no_drop_chk: assert (o0_o[VPOS] && o1_o[VPOS]);
    end

    // R8
    always_comb begin
        if (a_v != b_v)
            lone_pkt_chk: assert ((o0_o[VPOS] ^ o1_o[VPOS]) && !lose_o);
    end
endmodule

// File: rtl/omega_stage.sv
module omega_stage
    import omega_pkg::*;
#(
    parameter int P   = 8,
    parameter int W   = 8,
    parameter int STG = 0,
    parameter int DW  = $clog2(P),
    parameter int PW  = 1 + 2*DW + W
) (
    input  logic [P*PW-1:0] pkt_i,
    output logic [P*PW-1:0] pkt_o,
    output logic [P-1:0]    lose_o
);
    localparam int NSW = P / 2;

    logic [P*PW-1:0] shuf;
    logic [NSW-1:0]  lose;
    logic [DW-1:0]   lsrc [NSW];

    for (genvar i = 0; i < P; i++) begin : g_shuf
        localparam int R = shuffle_idx(i, DW);
        assign shuf[R*PW +: PW] = pkt_i[i*PW +: PW];
    end

    for (genvar k = 0; k < NSW; k++) begin : g_sw
        omega_switch #(.DW(DW), .W(W), .BIT(DW-1-STG), .PW(PW)) u_sw (
            .a_i        (shuf[(2*k)*PW +: PW]),
            .b_i        (shuf[(2*k+1)*PW +: PW]),
            .o0_o       (pkt_o[(2*k)*PW +: PW]),
            .o1_o       (pkt_o[(2*k+1)*PW +: PW]),
            .lose_o     (lose[k]),
            .lose_src_o (lsrc[k])
        );
    end

    always_comb begin
        lose_o = '0;
        for (int k = 0; k < NSW; k++)
            if (lose[k]) lose_o[lsrc[k]] = 1'b1;
    end
endmodule

// File: rtl/omega_net.sv
module omega_net #(
    parameter int P  = 8,
    parameter int W  = 8,
    parameter int DW = $clog2(P)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [P-1:0]    in_valid,
    input  logic [P*DW-1:0] in_dest,
    input  logic [P*W-1:0]  in_data,
    output logic [P-1:0]    out_valid,
    output logic [P*W-1:0]  out_data,
    output logic [P-1:0]    blocked
);
    localparam int PW = 1 + 2*DW + W;

    logic [P*PW-1:0] chain [DW+1];
    logic [P-1:0]    lose  [DW];
    logic [P-1:0]    blk_c;
    logic [P-1:0]    vld_c;
    logic [P*W-1:0]  dat_c;

    for (genvar i = 0; i < P; i++) begin : g_in
        localparam logic [DW-1:0] SRC = DW'(i);
        assign chain[0][i*PW +: PW] = {in_valid[i], in_dest[i*DW +: DW], SRC, in_data[i*W +: W]};
        assign vld_c[i]        = chain[DW][i*PW + PW - 1];
        assign dat_c[i*W +: W] = chain[DW][i*PW +: W];
    end

    for (genvar s = 0; s < DW; s++) begin : g_stg
        omega_stage #(.P(P), .W(W), .STG(s), .DW(DW), .PW(PW)) u_stg (
            .pkt_i  (chain[s]),
            .pkt_o  (chain[s+1]),
            .lose_o (lose[s])
        );
    end

    always_comb begin
        blk_c = '0;
        for (int s = 0; s < DW; s++) blk_c = blk_c | lose[s];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= '0;
            out_data  <= '0;
            blocked   <= '0;
        end else begin
            out_valid <= vld_c;
            out_data  <= dat_c;
            blocked   <= blk_c;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (out_valid == '0 && blocked == '0));

    // R7
    conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_valid) + $countones(blocked) == $countones($past(in_valid)));

    // R9
    blk_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked & ~$past(in_valid)) == '0);
endmodule

// File: tb/sim_omega_net.sv
`timescale 1ns/1ps
module sim_omega_net;
    localparam int P  = 8;
    localparam int W  = 8;
    localparam int DW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [P-1:0]    in_valid = '0;
    logic [P*DW-1:0] in_dest = '0;
    logic [P*W-1:0]  in_data = '0;
    logic [P-1:0]    out_valid;
    logic [P*W-1:0]  out_data;
    logic [P-1:0]    blocked;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    omega_net #(.P(P), .W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data), .blocked(blocked)
    );

    logic [P-1:0]   e_valid, e_blk;
    logic [P*W-1:0] e_data;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // reference model built from the R5 routing rule
    task automatic model(input logic [P-1:0] v, input logic [P*DW-1:0] d, input logic [P*W-1:0] x);
        logic          lv [P];
        int            ls [P];
        logic          nv [P];
        int            ns [P];
        e_valid = '0; e_blk = '0; e_data = '0;
        for (int i = 0; i < P; i++) begin lv[i] = v[i]; ls[i] = i; end
        for (int st = 0; st < DW; st++) begin
            for (int i = 0; i < P; i++) begin
                int r;
                r = ((i << 1) | (i >> (DW-1))) & (P-1);
                nv[r] = lv[i]; ns[r] = ls[i];
            end
            for (int i = 0; i < P; i++) begin lv[i] = 1'b0; ls[i] = 0; end
            for (int q = 0; q < P; q++) begin
                if (nv[q]) begin
                    int src, tgt;
                    src = ns[q];
                    tgt = (q & ~1) | int'(d[src*DW + (DW-1-st)]);
                    if (lv[tgt]) e_blk[src] = 1'b1;
                    else begin lv[tgt] = 1'b1; ls[tgt] = src; end
                end
            end
        end
        for (int j = 0; j < P; j++)
            if (lv[j]) begin
                e_valid[j] = 1'b1;
                e_data[j*W +: W] = x[ls[j]*W +: W];
            end
    endtask

    task automatic apply(input logic [P-1:0] v, input logic [P*DW-1:0] d, input logic [P*W-1:0] x, input string req);
        @(negedge clk);
        in_valid = v; in_dest = d; in_data = x;
        model(v, d, x);
        @(negedge clk);
        chk(req, "out_valid", 64'(out_valid), 64'(e_valid));
        chk(req, "blocked", 64'(blocked), 64'(e_blk));
        for (int j = 0; j < P; j++)
            if (e_valid[j]) chk(req, "out_data", 64'(out_data[j*W +: W]), 64'(e_data[j*W +: W]));
        chk("R7", "count", 64'($countones(out_valid) + $countones(blocked)), 64'($countones(v)));
    endtask

    function automatic logic [P*W-1:0] tagdata(input int salt);
        logic [P*W-1:0] r;
        for (int i = 0; i < P; i++) r[i*W +: W] = W'(salt * 16 + i);
        return r;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "out_valid", 64'(out_valid), 64'h0);
        chk("R1", "blocked", 64'(blocked), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "out_valid post", 64'(out_valid), 64'h0);
    endtask

    task automatic t_shifts();
        for (int c = 0; c < P; c++) begin
            logic [P*DW-1:0] d;
            for (int i = 0; i < P; i++) d[i*DW +: DW] = DW'((i + c) % P);
            apply('1, d, tagdata(c), "R4");
            chk("R4", "all delivered", 64'(out_valid), 64'hFF);
            chk("R3", "data at dest", 64'(out_data[((3 + c) % P)*W +: W]), 64'(c * 16 + 3));
        end
    endtask

    task automatic t_lone();
        for (int s = 0; s < P; s++)
            for (int t = 0; t < P; t++) begin
                logic [P*DW-1:0] d;
                d = '1;
                d[s*DW +: DW] = DW'(t);
                apply(P'(1) << s, d, tagdata(5), "R8");
                chk("R8", "lone at dest", 64'(out_valid), 64'(1) << t);
            end
    endtask

    task automatic t_example();
        logic [P*DW-1:0] d;
        d = '0;
        d[2*DW +: DW] = 3'd7;
        d[6*DW +: DW] = 3'd4;
        apply(8'b0100_0100, d, tagdata(9), "R6");
        chk("R6", "out_valid", 64'(out_valid), 64'h80);
        chk("R6", "blocked", 64'(blocked), 64'h40);
        chk("R6", "payload", 64'(out_data[7*W +: W]), 64'h92);
    endtask

    task automatic t_hotspot();
        logic [P*DW-1:0] d;
        for (int i = 0; i < P; i++) d[i*DW +: DW] = 3'd5;
        apply('1, d, tagdata(2), "R5");
        chk("R5", "single winner", 64'(out_valid), 64'h20);
        chk("R5", "seven blocked", 64'($countones(blocked)), 64'd7);
    endtask

    task automatic t_invalid();
        logic [P*DW-1:0] d;
        for (int i = 0; i < P; i++) d[i*DW +: DW] = 3'd1;
        apply(8'b0000_0000, d, tagdata(7), "R9");
        chk("R9", "none out", 64'(out_valid), 64'h0);
        d[4*DW +: DW] = 3'd1;
        apply(8'b0001_0000, d, tagdata(7), "R9");
        chk("R9", "invalid no contest", 64'(out_valid), 64'h02);
        chk("R9", "invalid no block", 64'(blocked), 64'h0);
    endtask

    task automatic t_latency();
        logic [P*DW-1:0] d;
        for (int i = 0; i < P; i++) d[i*DW +: DW] = 3'd0;
        apply('1, d, tagdata(3), "R2");
        @(negedge clk);
        in_valid = '0;
        @(negedge clk);
        chk("R2", "valid cleared", 64'(out_valid), 64'h0);
        chk("R2", "blocked cleared", 64'(blocked), 64'h0);
    endtask

    task automatic t_mixed();
        logic [31:0] lfsr;
        lfsr = 32'hACE1_2345;
        for (int n = 0; n < 200; n++) begin
            logic [P*DW-1:0] d;
            logic [P-1:0] v;
            for (int k = 0; k < 3; k++) lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            v = lfsr[7:0];
            d = lfsr[31:8];
            apply(v, d, tagdata(n), "R3");
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_shifts();
        t_lone();
        t_example();
        t_hotspot();
        t_invalid();
        t_latency();
        t_mixed();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule